// File: doc/BRIEF.md
# Conditional-Select Block Adder

A combinational adder/subtractor for wide operands, built from equal slices (eight slices of eight bits at the default 64-bit width). Each slice computes its two possible sum vectors at once, one for an incoming carry of 0 and one for an incoming carry of 1. It also reports a block generate and a block propagate bit. None of this waits for the real carry.

A separate block-carry chain takes the slice generate/propagate pairs and works out the true carry into every slice. It handles two positions per step. That late carry picks one of the two candidate vectors in each slice.

Subtraction uses the same hardware. The second operand is inverted bit by bit and a carry of one is injected into the lowest slice. The carry-out is the block carry that leaves the top slice, so it reads as "no borrow" in subtract mode. The result settles in the same cycle the inputs change. A width parameter lets the block be used at 32 bits as well.

Top module: `csa_adder`

## Requirements
- R1: With `sub_mode` = 0, `{carry_out, result}` equals the unsigned sum `in_a + in_b` over WIDTH+1 bits.
- R2: With `sub_mode` = 1, `result` equals `(in_a - in_b) mod 2^WIDTH`, and `carry_out` is 1 exactly when `in_a >= in_b` as unsigned numbers (1 means no borrow).
- R3: In add mode, `carry_out` is 1 exactly when the unsigned sum does not fit in WIDTH bits.
- R4: A carry raised in the lowest bit reaches the top through every slice. For example, all-ones plus one gives a zero `result` and `carry_out` = 1.
- R5: Each slice delivers the correct value whether its incoming block carry is 0 or 1. This holds for patterns where a carry enters some slice boundaries and not others.
- R6: The block holds no state. The outputs follow the inputs in the same cycle, and zero operands in add mode give a zero `result` and `carry_out` = 0.
- R7: Subtracting an operand from itself gives a zero `result` with `carry_out` = 1.
- R8: An instance with WIDTH = 32 and 8-bit slices meets R1 and R2 at its own width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | WIDTH | First operand (minuend when subtracting) |
| in_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the top slice; in subtract mode 1 means no borrow |

## Verification
A wrong block carry into a slice shows at the ports at once, in the same evaluation. That slice's bits of `result` come out too large or too small by one unit of the slice's weight, and the error is confined to that slice, so the bench uses operands whose carries stop at, or cross, chosen slice boundaries. A fault in the candidate-sum logic of a slice appears only when the selecting carry picks the faulty vector. Every slice is therefore driven with both carry-in values. A fault in the operand conditioning or the injected carry shows on every subtraction, and equal operands expose it most directly.

// File: rtl/csa_pkg.sv
package csa_pkg;
    // Default geometry of the adder
    localparam int unsigned CSA_WIDTH = 64;
    localparam int unsigned CSA_SLICE = 8;

    // Operation select encoding on sub_mode
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } csa_op_e;

    // Per-slice summary handed to the block-carry chain
    typedef struct packed {
        logic gen;   // slice produces a carry with carry-in 0
        logic prop;  // slice passes an incoming carry through
    } csa_gp_t;
endpackage

// File: rtl/csa_operand_cond.sv
// Operand conditioning: inverts the second operand and injects the
// initial carry when subtracting.
module csa_operand_cond
    import csa_pkg::*;
#(
    parameter int unsigned WIDTH = CSA_WIDTH
) (
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] op_b_cond,
    output logic             carry_inj
);
    csa_op_e op;

    always_comb begin
        op = csa_op_e'(sub_mode);
        unique case (op)
            OP_ADD: begin
                op_b_cond = op_b;
                carry_inj = 1'b0;
            end
            OP_SUB: begin
                op_b_cond = ~op_b;
                carry_inj = 1'b1;
            end
            default: begin
                op_b_cond = op_b;
                carry_inj = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/csa_slice.sv
// One slice: bit generate/propagate, then two carry vectors (carry-in 0
// and carry-in 1) resolved two bit positions per step, and the two
// candidate sums.
module csa_slice
    import csa_pkg::*;
#(
    parameter int unsigned SLICE = CSA_SLICE
) (
    input  logic [SLICE-1:0] sl_a,
    input  logic [SLICE-1:0] sl_b,
    output logic [SLICE-1:0] sum_c0,
    output logic [SLICE-1:0] sum_c1,
    output csa_gp_t          gp
);
    logic [SLICE-1:0] bit_g;
    logic [SLICE-1:0] bit_p;
    logic [SLICE:0]   cv0;
    logic [SLICE:0]   cv1;

    // Preliminary stage
    assign bit_g = sl_a & sl_b;
    assign bit_p = sl_a ^ sl_b;

    // Conditional carry stage, two positions per step
    always_comb begin
        logic pair_g;
        logic pair_p;
        pair_g = 1'b0;
        pair_p = 1'b0;
        cv0    = '0;
        cv1    = '0;
        cv1[0] = 1'b1;
        for (int k = 0; k < int'(SLICE); k += 2) begin
            cv0[k+1] = bit_g[k] | (bit_p[k] & cv0[k]);
            cv1[k+1] = bit_g[k] | (bit_p[k] & cv1[k]);
            if (k + 1 < int'(SLICE)) begin
                pair_g   = bit_g[k+1] | (bit_p[k+1] & bit_g[k]);
                pair_p   = bit_p[k+1] & bit_p[k];
                cv0[k+2] = pair_g | (pair_p & cv0[k]);
                cv1[k+2] = pair_g | (pair_p & cv1[k]);
            end
        end
    end

    // Conditional sum stage
    assign sum_c0  = bit_p ^ cv0[SLICE-1:0];
    assign sum_c1  = bit_p ^ cv1[SLICE-1:0];
    assign gp.gen  = cv0[SLICE];
    assign gp.prop = &bit_p;

    // R5: the carry-in-1 candidate is one above the carry-in-0 candidate
    always_comb begin
        a_r5_cand_step: assert (sum_c1 == SLICE'(sum_c0 + 1'b1))
            else $error("slice candidates differ by other than one");
    end

    // R3: a slice cannot both generate and fully propagate
    always_comb begin
        a_r3_gp_exclusive: assert (!(gp.gen && gp.prop))
            else $error("slice generate and propagate both set");
    end
endmodule

// File: rtl/csa_block_chain.sv
// Block-carry chain: resolves the carry into each slice from the slice
// generate/propagate pairs, two slices per step.
module csa_block_chain
    import csa_pkg::*;
#(
    parameter int unsigned NSL = CSA_WIDTH / CSA_SLICE
) (
    input  csa_gp_t [NSL-1:0] gp_in,
    input  logic              carry_in,
    output logic [NSL:0]      blk_carry
);
    always_comb begin
        logic grp_g;
        logic grp_p;
        grp_g        = 1'b0;
        grp_p        = 1'b0;
        blk_carry    = '0;
        blk_carry[0] = carry_in;
        for (int k = 0; k < int'(NSL); k += 2) begin
            blk_carry[k+1] = gp_in[k].gen | (gp_in[k].prop & blk_carry[k]);
            if (k + 1 < int'(NSL)) begin
                grp_g = gp_in[k+1].gen | (gp_in[k+1].prop & gp_in[k].gen);
                grp_p = gp_in[k+1].prop & gp_in[k].prop;
                blk_carry[k+2] = grp_g | (grp_p & blk_carry[k]);
            end
        end
    end

    // R4: when every slice propagates, the injected carry reaches the top
    always_comb begin
        logic all_prop;
        all_prop = 1'b1;
        for (int k = 0; k < int'(NSL); k++) begin
            all_prop = all_prop & gp_in[k].prop;
        end
        if (all_prop) begin
            a_r4_full_propagate: assert (blk_carry[NSL] == carry_in)
                else $error("carry lost across propagating slices");
        end
    end
endmodule

// File: rtl/csa_adder.sv
module csa_adder
    import csa_pkg::*;
#(
    parameter int unsigned WIDTH = CSA_WIDTH,
    parameter int unsigned SLICE = CSA_SLICE
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int unsigned NSL = WIDTH / SLICE;

    logic [WIDTH-1:0] b_cond;
    logic             c_inj;
    logic [WIDTH-1:0] cand0;
    logic [WIDTH-1:0] cand1;
    csa_gp_t [NSL-1:0] slice_gp;
    logic [NSL:0]     bcarry;

    csa_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .op_b      (in_b),
        .sub_mode  (sub_mode),
        .op_b_cond (b_cond),
        .carry_inj (c_inj)
    );

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        csa_slice #(.SLICE(SLICE)) u_slice (
            .sl_a   (in_a  [s*SLICE +: SLICE]),
            .sl_b   (b_cond[s*SLICE +: SLICE]),
            .sum_c0 (cand0 [s*SLICE +: SLICE]),
            .sum_c1 (cand1 [s*SLICE +: SLICE]),
            .gp     (slice_gp[s])
        );
        // Late block carry picks the slice result
        assign result[s*SLICE +: SLICE] =
            bcarry[s] ? cand1[s*SLICE +: SLICE] : cand0[s*SLICE +: SLICE];
    end

    csa_block_chain #(.NSL(NSL)) u_chain (
        .gp_in     (slice_gp),
        .carry_in  (c_inj),
        .blk_carry (bcarry)
    );

    assign carry_out = bcarry[NSL];

    // R1 / R2 / R3: ports agree with arithmetic on the raw operands
    always_comb begin
        if (sub_mode == 1'b0) begin
            a_r1_add_value: assert ({carry_out, result} == ({1'b0, in_a} + {1'b0, in_b}))
                else $error("add result mismatch");
        end else begin
            a_r2_sub_value: assert ((result == WIDTH'(in_a - in_b)) && (carry_out == (in_a >= in_b)))
                else $error("subtract result mismatch");
        end
    end
endmodule

// File: tb/test_csa_adder.sv
module test_csa_adder;
    localparam int W  = 64;
    localparam int W2 = 32;
    localparam int NV = 12;
    localparam int NRAND = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]  a, b, res;
    logic          sm, co;
    logic [W2-1:0] a2, b2, res2;
    logic          sm2, co2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    csa_adder i_csa_adder (
        .in_a(a), .in_b(b), .sub_mode(sm), .result(res), .carry_out(co)
    );

    csa_adder #(.WIDTH(W2), .SLICE(8)) i_csa_adder_w32 (
        .in_a(a2), .in_b(b2), .sub_mode(sm2), .result(res2), .carry_out(co2)
    );

    // Vector table: {sub_mode, a, b}
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
        {1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        {1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001},
        {1'b0, 64'hFF00_FF00_FF00_FF00, 64'h0100_0100_0100_0100},
        {1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
        {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},
        {1'b1, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_0001},
        {1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D},
        {1'b1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0009},
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        {1'b1, 64'h0100_0000_0100_0000, 64'h00FF_FFFF_00FF_FFFF}
    };

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] r;
        if (s) begin
            r[W-1:0] = x - y;
            r[W]     = (x >= y);
        end else begin
            r = {1'b0, x} + {1'b0, y};
        end
        return r;
    endfunction

    function automatic logic [W2:0] model32(input logic s, input logic [W2-1:0] x, input logic [W2-1:0] y);
        logic [W2:0] r;
        if (s) begin
            r[W2-1:0] = x - y;
            r[W2]     = (x >= y);
        end else begin
            r = {1'b0, x} + {1'b0, y};
        end
        return r;
    endfunction

    task automatic apply(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        sm = s; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic apply32(input logic s, input logic [W2-1:0] x, input logic [W2-1:0] y);
        @(posedge clk);
        sm2 = s; a2 = x; b2 = y;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        a = '0; b = '0; sm = 1'b0;
        a2 = '0; b2 = '0; sm2 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R6: zero operands, add mode
        @(negedge clk);
        check("R6 zero-in", {co, res}, '0);

        // Table walk: R1 for add rows, R2 for subtract rows
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
            check(VEC[i][2*W] ? "R2 table" : "R1 table", {co, res},
                  model(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]));
        end

        // R4: ripple through all slices
        apply(1'b0, {W{1'b1}}, 64'd1);
        check("R4 full ripple", {co, res}, {1'b1, {W{1'b0}}});
        apply(1'b1, 64'd0, 64'd0);
        check("R4 sub injected carry ripple", {co, res}, {1'b1, {W{1'b0}}});

        // R3: overflow and no overflow
        apply(1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
        check("R3 no overflow", {co, res}, {1'b0, {W{1'b1}}});
        apply(1'b0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF);
        check("R3 overflow", {co, res}, {1'b1, {W{1'b0}}});

        // R5: each slice boundary carried alone
        for (int s = 0; s < W / 8; s++) begin
            logic [W-1:0] x;
            x = 64'hFF << (8 * s);
            apply(1'b0, x, 64'h1 << (8 * s));
            check("R5 single boundary", {co, res}, model(1'b0, x, 64'h1 << (8 * s)));
        end
        apply(1'b0, 64'h00FF_0000_FF00_00FF, 64'h0001_0000_0100_0001);
        check("R5 mixed boundaries", {co, res}, {1'b0, 64'h0100_0001_0000_0100});

        // R7: equal operands
        apply(1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
        check("R7 self subtract", {co, res}, {1'b1, {W{1'b0}}});

        // R6: same-cycle response after mode flip, inputs held
        apply(1'b0, 64'd7, 64'd3);
        check("R6 add then", {co, res}, {1'b0, 64'd10});
        apply(1'b1, 64'd7, 64'd3);
        check("R6 flip to sub", {co, res}, {1'b1, 64'd4});

        // R1 / R2 random
        for (int i = 0; i < NRAND; i++) begin
            logic [W-1:0] x, y;
            logic s;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            s = i[0];
            apply(s, x, y);
            check(s ? "R2 random" : "R1 random", {co, res}, model(s, x, y));
        end

        // R8: 32-bit instance
        apply32(1'b0, 32'hFFFF_FFFF, 32'h1);
        check("R8 w32 ripple", {32'd0, co2, res2}, {32'd0, 1'b1, 32'h0});
        apply32(1'b1, 32'h5, 32'h9);
        check("R8 w32 borrow", {32'd0, co2, res2}, {32'd0, 1'b0, 32'hFFFF_FFFC});
        for (int i = 0; i < 100; i++) begin
            logic [W2-1:0] x, y;
            logic s;
            x = $urandom;
            y = $urandom;
            s = i[1];
            apply32(s, x, y);
            check("R8 w32 random", {32'd0, co2, res2}, {32'd0, model32(s, x, y)});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule